// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU bus and the memory space of a plug-in cartridge. CPU writes that land in the low 32 KiB are not stored. They are decoded as control writes that move a 16 KiB ROM bank window, choose an 8 KiB external RAM bank and switch the external RAM on or off. For reads, the block turns the CPU address into a physical ROM address and a physical RAM address. It also gates the external RAM: reads return 0xFF and writes are dropped while the RAM is off.

The parameter `CART_TYPE` holds the cartridge type byte and fixes the controller behaviour at elaboration time. There are three behaviours and a "no controller" case. `ROM_BANKS` gives the size of the ROM in 16 KiB banks. A bank switch that would point past the end of the ROM is refused, and the old bank stays selected.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write with `cpuAddr[15:13]`=0 and data 0x0A turns the external RAM on. The same write with data 0x00 turns it off. Any other data value leaves the on/off state unchanged.
- R2: With type 0x01–0x03 (variant A), a write with `cpuAddr[15:13]`=1 takes data bits [4:0] as the bank, with 0 replaced by 1. The result is ORed with bits [6:5] of the current bank.
- R3: With type 0x0F–0x13 (variant B), a write with `cpuAddr[15:13]`=1 takes data bits [6:0] as the bank, with 0 replaced by 1.
- R4: In variant B, a write with `cpuAddr[15:13]`=2 and data below 4 selects that RAM bank, and larger values are ignored. The other variants ignore this region. Writes to 0x4000–0x7FFF never change the ROM bank.
- R5: With type 0x19–0x1E (variant C), a write with `cpuAddr[15:13]`=1 takes data bits [6:0] unchanged, so bank 0 can be mapped into the switchable window.
- R6: A ROM bank value that is not below `ROM_BANKS` is rejected, and the previous bank is kept.
- R7: For `cpuAddr[14]`=0, `romAddr` is `{0, cpuAddr[13:0]}`. For `cpuAddr[14]`=1, it is `{romBank, cpuAddr[13:0]}`.
- R8: `ramAddr` is `{ramBank, cpuAddr[12:0]}`. `ramRdOut` equals `ramRdIn` while the RAM is on and 0xFF while it is off. `ramWrStrobe` is high only for a write to 0xA000–0xBFFF while the RAM is on.
- R9: After reset the ROM bank is 1, the RAM bank is 0 and the RAM is off.
- R10: Type 0x00, 0x08, 0x09 and any type not listed above mean no controller. All writes to 0x0000–0x7FFF are then ignored: the ROM bank stays 1 and the RAM stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuWrEn | input | 1 | CPU write strobe, sampled at the rising edge |
| ramRdIn | input | 8 | Data read from external RAM |
| romAddr | output | 14+log2(ROM_BANKS) | Physical ROM read address |
| ramAddr | output | 15 | Physical external RAM address |
| ramWrStrobe | output | 1 | Gated external RAM write enable |
| ramRdOut | output | 8 | RAM read data seen by the CPU (0xFF when off) |

## Verification
On every cycle, the assertions check four things:
- the RAM only turns on in the cycle after a 0x0A write to region 0;
- the ROM bank and RAM bank only move after a write to their own regions;
- a bank load never carries a value at or above `ROM_BANKS`;
- variants A and B never hold bank 0.

The exact bank values are shown only by the bench scenarios. These cover the zero remap, the bit merge, the rejection of oversized values, the 0xFF read-back while the RAM is off, and the three variants plus the no-controller case driven side by side from one bus.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int BANK_W = 7;
  localparam int RAMB_W = 2;

  typedef enum logic [1:0] {VAR_NONE, VAR_A, VAR_B, VAR_C} cart_variant_e;

  typedef struct packed {
    logic              romLoad;
    logic [BANK_W-1:0] romVal;
    logic              ramLoad;
    logic [RAMB_W-1:0] ramVal;
    logic              ramEnSet;
    logic              ramEnClr;
  } bank_strobe_t;

  function automatic cart_variant_e typeToVariant(input logic [7:0] t);
    case (t)
      8'h01, 8'h02, 8'h03:                        return VAR_A;
      8'h0F, 8'h10, 8'h11, 8'h12, 8'h13:          return VAR_B;
      8'h19, 8'h1A, 8'h1B, 8'h1C, 8'h1D, 8'h1E:   return VAR_C;
      default:                                    return VAR_NONE;
    endcase
  endfunction
endpackage

// File: rtl/cart_bank_ctrl_decode.sv
module cart_bank_ctrl_decode
  import cart_bank_pkg::*;
#(
  parameter cart_variant_e VARIANT   = VAR_NONE,
  parameter int            ROM_BANKS = 32
) (
  input  logic [2:0]        wrRegion,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  input  logic [BANK_W-1:0] curRomBank,
  output bank_strobe_t      strb
);
  localparam logic [BANK_W:0] ROM_LIM = (BANK_W+1)'(ROM_BANKS);
  localparam logic            HAS_CTRL = (VARIANT != VAR_NONE);

  logic [BANK_W-1:0] cand;
  logic              inRange;

  // Candidate bank from the written value, per variant rules
  always_comb begin
    case (VARIANT)
      VAR_A:   cand = {curRomBank[6:5], (wrData[4:0] == 5'd0) ? 5'd1 : wrData[4:0]};
      VAR_B:   cand = (wrData[6:0] == 7'd0) ? 7'd1 : wrData[6:0];
      VAR_C:   cand = wrData[6:0];
      default: cand = curRomBank;
    endcase
    inRange = ({1'b0, cand} < ROM_LIM);
  end

  always_comb begin
    strb.romLoad  = wrEn && HAS_CTRL && (wrRegion == 3'd1) && inRange;
    strb.romVal   = cand;
    strb.ramLoad  = wrEn && (VARIANT == VAR_B) && (wrRegion == 3'd2)
                    && (wrData[7:RAMB_W] == '0);
    strb.ramVal   = wrData[RAMB_W-1:0];
    strb.ramEnSet = wrEn && HAS_CTRL && (wrRegion == 3'd0) && (wrData == 8'h0A);
    strb.ramEnClr = wrEn && HAS_CTRL && (wrRegion == 3'd0) && (wrData == 8'h00);
  end
endmodule

// File: rtl/cart_bank_ctrl_regs.sv
module cart_bank_ctrl_regs
  import cart_bank_pkg::*;
#(
  parameter cart_variant_e VARIANT   = VAR_NONE,
  parameter int            ROM_BANKS = 32,
  localparam int           ROM_BW    = $clog2(ROM_BANKS),
  localparam int           ROM_AW    = 14 + ROM_BW,
  localparam int           RAM_AW    = 13 + RAMB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  bank_strobe_t      strb,
  input  logic [15:0]       cpuAddr,
  input  logic              cpuWrEn,
  input  logic [7:0]        ramRdIn,
  output logic [BANK_W-1:0] curRomBank,
  output logic              ramOn,
  output logic [ROM_AW-1:0] romAddr,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramWrStrobe,
  output logic [7:0]        ramRdOut
);
  localparam logic [BANK_W:0] ROM_LIM = (BANK_W+1)'(ROM_BANKS);

  logic [RAMB_W-1:0] ramBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curRomBank <= BANK_W'(1);
      ramBank    <= '0;
      ramOn      <= 1'b0;
    end else begin
      if (strb.romLoad)  curRomBank <= strb.romVal;
      if (strb.ramLoad)  ramBank    <= strb.ramVal;
      if (strb.ramEnSet) ramOn      <= 1'b1;
      else if (strb.ramEnClr) ramOn <= 1'b0;
    end
  end

  // Read address formation and RAM gating
  always_comb begin
    romAddr     = cpuAddr[14] ? {curRomBank[ROM_BW-1:0], cpuAddr[13:0]}
                              : {{ROM_BW{1'b0}}, cpuAddr[13:0]};
    ramAddr     = {ramBank, cpuAddr[12:0]};
    ramWrStrobe = cpuWrEn && (cpuAddr[15:13] == 3'd5) && ramOn;
    ramRdOut    = ramOn ? ramRdIn : 8'hFF;
  end

  AST_LOAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.romLoad |-> ({1'b0, strb.romVal} < ROM_LIM)); // R6

  generate
    if (VARIANT == VAR_A || VARIANT == VAR_B) begin : g_nonzero
      AST_BANK_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
        curRomBank != '0); // R3
    end
  endgenerate
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter logic [7:0] CART_TYPE = 8'h19,
  parameter int         ROM_BANKS = 32,
  localparam int        ROM_AW    = 14 + $clog2(ROM_BANKS),
  localparam int        RAM_AW    = 13 + RAMB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuWrData,
  input  logic              cpuWrEn,
  input  logic [7:0]        ramRdIn,
  output logic [ROM_AW-1:0] romAddr,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramWrStrobe,
  output logic [7:0]        ramRdOut
);
  localparam cart_variant_e VARIANT = typeToVariant(CART_TYPE);

  bank_strobe_t      strb;
  logic [BANK_W-1:0] curRomBank;
  logic              ramOn;

  cart_bank_ctrl_decode #(.VARIANT(VARIANT), .ROM_BANKS(ROM_BANKS)) u_decode (
    .wrRegion  (cpuAddr[15:13]),
    .wrData    (cpuWrData),
    .wrEn      (cpuWrEn),
    .curRomBank(curRomBank),
    .strb      (strb)
  );

  cart_bank_ctrl_regs #(.VARIANT(VARIANT), .ROM_BANKS(ROM_BANKS)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cpuAddr    (cpuAddr),
    .cpuWrEn    (cpuWrEn),
    .ramRdIn    (ramRdIn),
    .curRomBank (curRomBank),
    .ramOn      (ramOn),
    .romAddr    (romAddr),
    .ramAddr    (ramAddr),
    .ramWrStrobe(ramWrStrobe),
    .ramRdOut   (ramRdOut)
  );

  AST_ENABLE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramOn) |-> $past(cpuWrEn && cpuAddr[15:13] == 3'd0 && cpuWrData == 8'h0A)); // R1

  AST_ROM_CHANGE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (curRomBank != $past(curRomBank)) |-> $past(cpuWrEn && cpuAddr[15:13] == 3'd1)); // R4

  AST_RAM_BANK_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (ramAddr[RAM_AW-1:13] != $past(ramAddr[RAM_AW-1:13]))
      |-> $past(cpuWrEn && cpuAddr[15:13] == 3'd2)); // R4
endmodule

// File: tb/cart_bank_ctrl_bench.sv
module cart_bank_ctrl_bench;
  localparam int NB = 32;
  localparam int RA = 19;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = 16'h0000;
  logic [7:0]  cpuWrData = 8'h00;
  logic        cpuWrEn = 1'b0;
  logic [7:0]  ramRdIn = 8'h5A;

  logic [RA-1:0] romA, romB, romC, romN;
  logic [14:0]   ramAA, ramAB, ramAC, ramAN;
  logic          wsA, wsB, wsC, wsN;
  logic [7:0]    rdA, rdB, rdC, rdN;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cart_bank_ctrl #(.CART_TYPE(8'h19), .ROM_BANKS(NB)) u_cart_bank_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuWrEn(cpuWrEn),
    .ramRdIn(ramRdIn), .romAddr(romC), .ramAddr(ramAC), .ramWrStrobe(wsC), .ramRdOut(rdC));
  cart_bank_ctrl #(.CART_TYPE(8'h01), .ROM_BANKS(NB)) u_cart_bank_ctrl_a (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuWrEn(cpuWrEn),
    .ramRdIn(ramRdIn), .romAddr(romA), .ramAddr(ramAA), .ramWrStrobe(wsA), .ramRdOut(rdA));
  cart_bank_ctrl #(.CART_TYPE(8'h11), .ROM_BANKS(NB)) u_cart_bank_ctrl_b (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuWrEn(cpuWrEn),
    .ramRdIn(ramRdIn), .romAddr(romB), .ramAddr(ramAB), .ramWrStrobe(wsB), .ramRdOut(rdB));
  cart_bank_ctrl #(.CART_TYPE(8'h22), .ROM_BANKS(NB)) u_cart_bank_ctrl_n (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuWrEn(cpuWrEn),
    .ramRdIn(ramRdIn), .romAddr(romN), .ramAddr(ramAN), .ramWrStrobe(wsN), .ramRdOut(rdN));

  // {address, data, expected bank A, B, C} read back at 0x4000
  localparam int NV = 10;
  localparam logic [38:0] VEC [NV] = '{
    {16'h2000, 8'h05, 5'd5,  5'd5,  5'd5 },
    {16'h3FFF, 8'h00, 5'd1,  5'd1,  5'd0 },
    {16'h2000, 8'h1F, 5'd31, 5'd31, 5'd31},
    {16'h2000, 8'h20, 5'd1,  5'd31, 5'd31},
    {16'h2000, 8'h45, 5'd5,  5'd31, 5'd31},
    {16'h4000, 8'h02, 5'd5,  5'd31, 5'd31},
    {16'h6000, 8'h10, 5'd5,  5'd31, 5'd31},
    {16'h2000, 8'h13, 5'd19, 5'd19, 5'd19},
    {16'h0000, 8'h0A, 5'd19, 5'd19, 5'd19},
    {16'h2000, 8'h00, 5'd1,  5'd1,  5'd0 }
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic setRead(input logic [15:0] a);
    cpuAddr = a;
    #1;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    setRead(16'h4000);
    chk("R9 reset rom bank C", 32'(romC[18:14]), 32'd1);
    chk("R9 reset rom bank A", 32'(romA[18:14]), 32'd1);
    chk("R9 reset ram off", 32'(rdC), 32'hFF);
    rstN = 1'b1;
    @(negedge clk);
    setRead(16'hA000);
    chk("R9 ram bank 0", 32'(ramAB[14:13]), 32'd0);

    // Vector walk: R2/R3/R5/R6 bank rules
    for (int i = 0; i < NV; i++) begin
      doWrite(VEC[i][38:23], VEC[i][22:15]);
      setRead(16'h4000);
      chk($sformatf("R2 vec%0d variant A", i), 32'(romA[18:14]), 32'(VEC[i][14:10]));
      chk($sformatf("R3/R6 vec%0d variant B", i), 32'(romB[18:14]), 32'(VEC[i][9:5]));
      chk($sformatf("R5/R6 vec%0d variant C", i), 32'(romC[18:14]), 32'(VEC[i][4:0]));
    end

    // R10: no controller ignored every write, including the 0x0A enable
    chk("R10 none bank stays 1", 32'(romN[18:14]), 32'd1);
    setRead(16'hA000);
    chk("R10 none ram stays off", 32'(rdN), 32'hFF);

    // R7: address formation
    doWrite(16'h2000, 8'h13);
    setRead(16'h1234);
    chk("R7 fixed window", 32'(romC), 32'h01234);
    setRead(16'h7ABC);
    chk("R7 switch window", 32'(romC), {13'd0, 5'd19, 14'h3ABC});

    // R1: enable / disable / other values ignored
    setRead(16'hA000);
    chk("R1 ram on", 32'(rdC), 32'h5A);
    doWrite(16'h0000, 8'h05);
    setRead(16'hA000);
    chk("R1 other value keeps on", 32'(rdC), 32'h5A);
    doWrite(16'h1FFF, 8'h00);
    setRead(16'hA000);
    chk("R1 ram off", 32'(rdC), 32'hFF);
    doWrite(16'h0000, 8'h1A);
    setRead(16'hA000);
    chk("R1 other value keeps off", 32'(rdC), 32'hFF);
    doWrite(16'h0000, 8'h0A);

    // R8: gated write strobe and RAM address
    @(negedge clk);
    cpuAddr = 16'hA123; cpuWrData = 8'h77; cpuWrEn = 1'b1;
    #1;
    chk("R8 strobe when on", 32'(wsC), 32'd1);
    chk("R8 ram address", 32'(ramAC), 32'h0123);
    @(negedge clk);
    cpuWrEn = 1'b0;
    doWrite(16'h0000, 8'h00);
    cpuAddr = 16'hA123; cpuWrEn = 1'b1;
    #1;
    chk("R8 strobe blocked when off", 32'(wsC), 32'd0);
    @(negedge clk);
    cpuWrEn = 1'b0;

    // R4: RAM bank select only in variant B, value below 4
    doWrite(16'h4000, 8'h03);
    setRead(16'hA123);
    chk("R4 B ram bank 3", 32'(ramAB), {17'd0, 2'd3, 13'h0123});
    chk("R4 A ignores region 2", 32'(ramAA), 32'h0123);
    doWrite(16'h5FFF, 8'h04);
    setRead(16'hA123);
    chk("R4 B value 4 ignored", 32'(ramAB[14:13]), 32'd3);

    // R9: reset again from a non-default state
    @(negedge clk);
    rstN = 1'b0;
    setRead(16'h4000);
    chk("R9 rerun rom bank B", 32'(romB[18:14]), 32'd1);
    setRead(16'hA000);
    chk("R9 rerun ram bank B", 32'(ramAB[14:13]), 32'd0);
    doWrite(16'h0000, 8'h0A);
    chk("R9 ram off in reset", 32'(rdB), 32'hFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule